// File: doc/BRIEF.md
# Masked Calendar Alarm Matcher

This block watches a running calendar, supplied as BCD fields, and raises an alarm interrupt when the calendar reaches programmed values. A register interface holds six alarm fields: seconds, minutes, hours, day of month, month and a three-digit year. It also holds a control word. That word has one compare enable per field and a master enable.

The calendar itself is counted elsewhere. That counter presents the already-advanced time together with a one-cycle `sec_tick` strobe. On each strobe the block compares every enabled field against its alarm value. If any one enabled field matches, the pending flag is set and the interrupt line rises. It does not require all enabled fields to match. Software clears the flag by writing a one to its bit in the status register.

The month arrives as the usual 1-based BCD value (0x01 to 0x12). The block compares a zero-based BCD index (0x00 to 0x11) against the month alarm field. Software must therefore program that field one lower than the month it reads back. All pins are plain control and status signals. There is no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `cal_alarm_matcher`

## Requirements
- R1: After reset, every register reads back zero, and `alarm_irq` and `alarm_pending` are low.
- R2: Writes store masked values. The register select codes are 0 = control, 1 = seconds, 2 = minutes, 3 = hours, 4 = day, 5 = month, 6 = year and 7 = status. Control keeps bits 6:0, seconds and minutes keep 6:0, hours and day keep 5:0, month keeps 4:0 and year keeps 11:0. Each register reads back its stored value, zero-extended.
- R3: Control bits 0..5 enable the compare of seconds, minutes, hours, day, month and year respectively. A field whose bit is clear never causes an alarm.
- R4: With control bit 6 (master enable) clear, no alarm is raised, whatever the fields hold.
- R5: On a strobe with the master enable set, the alarm is raised when at least one enabled field equals its alarm register.
- R6: A raised alarm sets `alarm_pending`, status bit 1 and `alarm_irq` on the clock edge that samples the strobe. They are visible one cycle after the strobe cycle.
- R7: Writing status with bit 1 set clears the pending flag and lowers `alarm_irq`. Status bit 0 of a write has no effect on them.
- R8: The month field is compared with the calendar month minus one in BCD. For example, calendar 0x10 matches alarm 0x09, and calendar 0x01 matches alarm 0x00.
- R9: If a clearing write and an alarm happen in the same cycle, the flag ends set.
- R10: Without a strobe, no alarm is raised, even when fields match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| sec_tick | input | 1 | One-cycle strobe: calendar has just advanced |
| cal_sec | input | 8 | Calendar seconds, BCD |
| cal_min | input | 8 | Calendar minutes, BCD |
| cal_hour | input | 8 | Calendar hours, BCD |
| cal_mday | input | 8 | Calendar day of month, BCD |
| cal_month | input | 8 | Calendar month, 1-based BCD |
| cal_year | input | 12 | Calendar year, three BCD digits |
| alarm_irq | output | 1 | Alarm interrupt |
| alarm_pending | output | 1 | Alarm pending flag (status bit 1) |

## Verification
The main sweep tries every 7-bit control word against every 6-bit pattern of which calendar fields match. This covers the master enable, each per-field enable, and the difference between any-match and all-match behaviour. It also catches a field wired to the wrong enable bit.

Separate patterns check the following:
- all-ones writes, which expose each write mask;
- a month pair that separates the zero-based compare from the 1-based one;
- a bit-0-only status write;
- a clear that collides with a new alarm;
- matching fields held without a strobe.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int NF     = 6;   // alarm fields
  localparam int FW     = 12;  // widest field (year)
  localparam int CTRL_W = NF + 1;
  localparam int GEN_BIT = NF;
  localparam int SELW   = 3;

  localparam logic [SELW-1:0] SEL_CTRL = 3'd0;
  localparam logic [SELW-1:0] SEL_STAT = 3'd7;
  localparam int STAT_ALM_BIT = 1;

  // field index i lives at select code i+1
  function automatic logic [FW-1:0] field_mask(input int i);
    case (i)
      0, 1:    return 12'h07F;
      2, 3:    return 12'h03F;
      4:       return 12'h01F;
      default: return 12'hFFF;
    endcase
  endfunction

  // 1-based BCD month to zero-based BCD index
  function automatic logic [7:0] bcd_dec(input logic [7:0] v);
    if (v[3:0] == 4'd0) return {v[7:4] - 4'd1, 4'd9};
    else                return {v[7:4], v[3:0] - 4'd1};
  endfunction
endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
  import cal_alarm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic [SELW-1:0]        sel,
  input  logic [DW-1:0]          wdata,
  input  logic                   pending,
  output logic [DW-1:0]          rdata,
  output logic [CTRL_W-1:0]      ctrl,
  output logic [NF-1:0][FW-1:0]  alm,
  output logic                   clr_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) ctrl <= '0;
    else if (wr && sel == SEL_CTRL) ctrl <= wdata[CTRL_W-1:0];
  end

  for (genvar i = 0; i < NF; i++) begin : g_fld
    localparam logic [SELW-1:0] CODE = SELW'(i + 1);
    always_ff @(posedge clk) begin
      if (!rst_n) alm[i] <= '0;
      else if (wr && sel == CODE) alm[i] <= wdata[FW-1:0] & field_mask(i);
    end
  end

  assign clr_req = wr && (sel == SEL_STAT) && wdata[STAT_ALM_BIT];

  always_comb begin
    rdata = '0;
    if (sel == SEL_CTRL) rdata[CTRL_W-1:0] = ctrl;
    else if (sel == SEL_STAT) rdata[STAT_ALM_BIT] = pending;
    else rdata[FW-1:0] = alm[int'(sel) - 1];
  end

  a_r2_sec_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == 3'd1) |=> alm[0] == {5'd0, $past(wdata[6:0])});
  a_r2_month_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == 3'd5) |=> alm[4] == {7'd0, $past(wdata[4:0])});
  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel == SEL_CTRL) |=> $stable(ctrl));
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_alarm_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic [CTRL_W-1:0]      ctrl,
  input  logic [NF-1:0][FW-1:0]  alm,
  input  logic [NF-1:0][FW-1:0]  cal,
  output logic                   fire
);
  logic [NF-1:0] hit;

  for (genvar i = 0; i < NF; i++) begin : g_cmp
    assign hit[i] = ctrl[i] && (cal[i] == alm[i]);
  end

  assign fire = tick && ctrl[GEN_BIT] && (|hit);

  a_r4_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[GEN_BIT] |-> !fire);
  a_r10_tick_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> !fire);
  a_r3_no_enable_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[NF-1:0] == '0) |-> !fire);
endmodule

// File: rtl/cal_alarm_flag.sv
module cal_alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic clr,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (!rst_n)    pending <= 1'b0;
    else if (fire) pending <= 1'b1;
    else if (clr)  pending <= 1'b0;
  end

  a_r6_set_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pending);
  a_r6_rise_needs_fire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(fire));
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !fire) |=> !pending);
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && fire) |=> pending);
endmodule

// File: rtl/cal_alarm_matcher.sv
module cal_alarm_matcher
  import cal_alarm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [2:0]      reg_sel,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            sec_tick,
  input  logic [7:0]      cal_sec,
  input  logic [7:0]      cal_min,
  input  logic [7:0]      cal_hour,
  input  logic [7:0]      cal_mday,
  input  logic [7:0]      cal_month,
  input  logic [11:0]     cal_year,
  output logic            alarm_irq,
  output logic            alarm_pending
);
  logic [CTRL_W-1:0]     ctrl;
  logic [NF-1:0][FW-1:0] alm;
  logic [NF-1:0][FW-1:0] cal;
  logic                  clr_req, fire, pending;

  assign cal[0] = {4'd0, cal_sec};
  assign cal[1] = {4'd0, cal_min};
  assign cal[2] = {4'd0, cal_hour};
  assign cal[3] = {4'd0, cal_mday};
  assign cal[4] = {4'd0, bcd_dec(cal_month)};
  assign cal[5] = cal_year;

  cal_alarm_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .pending(pending), .rdata(reg_rdata), .ctrl(ctrl), .alm(alm),
    .clr_req(clr_req)
  );

  cal_alarm_cmp u_cmp (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick), .ctrl(ctrl), .alm(alm),
    .cal(cal), .fire(fire)
  );

  cal_alarm_flag u_flag (
    .clk(clk), .rst_n(rst_n), .fire(fire), .clr(clr_req), .pending(pending)
  );

  assign alarm_pending = pending;
  assign alarm_irq     = pending;

  a_r6_irq_tracks_flag: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq == reg_rdata[1] || reg_sel != 3'd7);
endmodule

// File: tb/cal_alarm_matcher_test.sv
module cal_alarm_matcher_test;
  logic clk = 0;
  logic rst_n = 0;
  logic reg_wr = 0;
  logic [2:0] reg_sel = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic sec_tick = 0;
  logic [7:0] cal_sec = 0, cal_min = 0, cal_hour = 0, cal_mday = 0, cal_month = 8'h01;
  logic [11:0] cal_year = 0;
  logic alarm_irq, alarm_pending;
  int vectors = 0, errors = 0;

  always #2 clk = ~clk;

  cal_alarm_matcher uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_tick(sec_tick),
    .cal_sec(cal_sec), .cal_min(cal_min), .cal_hour(cal_hour),
    .cal_mday(cal_mday), .cal_month(cal_month), .cal_year(cal_year),
    .alarm_irq(alarm_irq), .alarm_pending(alarm_pending)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input string req, input logic [2:0] s, input logic [15:0] exp);
    reg_sel = s; #0.5;
    check(req, reg_rdata, exp);
  endtask

  // pattern bit set -> field matches the programmed alarm
  task automatic drive_cal(input logic [5:0] p);
    cal_sec   = p[0] ? 8'h45 : 8'h46;
    cal_min   = p[1] ? 8'h30 : 8'h31;
    cal_hour  = p[2] ? 8'h23 : 8'h22;
    cal_mday  = p[3] ? 8'h31 : 8'h30;
    cal_month = p[4] ? 8'h10 : 8'h12;
    cal_year  = p[5] ? 12'h924 : 12'h925;
  endtask

  task automatic tick_once;
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int s = 0; s < 8; s++) rd("R1", 3'(s), 16'h0);
    check("R1 irq", {15'd0, alarm_irq}, 16'd0);

    // R2 masks
    for (int s = 0; s < 7; s++) wr(3'(s), 16'hFFFF);
    rd("R2 ctrl", 3'd0, 16'h007F);
    rd("R2 sec",  3'd1, 16'h007F);
    rd("R2 min",  3'd2, 16'h007F);
    rd("R2 hour", 3'd3, 16'h003F);
    rd("R2 day",  3'd4, 16'h003F);
    rd("R2 mon",  3'd5, 16'h001F);
    rd("R2 year", 3'd6, 16'h0FFF);

    // program alarm values
    wr(3'd0, 16'h0);
    wr(3'd1, 16'h0045); wr(3'd2, 16'h0030); wr(3'd3, 16'h0023);
    wr(3'd4, 16'h0031); wr(3'd5, 16'h0009); wr(3'd6, 16'h0924);
    rd("R2 year back", 3'd6, 16'h0924);

    // R3 R4 R5 R6 sweep
    for (int m = 0; m < 128; m++) begin
      wr(3'd0, 16'(m));
      for (int p = 0; p < 64; p++) begin
        logic e;
        e = m[6] && ((m[5:0] & p[5:0]) != 6'd0);
        drive_cal(6'(p));
        tick_once();
        check("R3/R4/R5/R6 pending", {15'd0, alarm_pending}, {15'd0, e});
        check("R6 irq", {15'd0, alarm_irq}, {15'd0, e});
        if (e) begin
          wr(3'd7, 16'h0002);
          check("R7 cleared", {15'd0, alarm_pending}, 16'd0);
        end
      end
    end

    // R10: matching fields, no strobe
    wr(3'd0, 16'h007F);
    drive_cal(6'h3F);
    repeat (4) @(negedge clk);
    check("R10 no tick", {15'd0, alarm_pending}, 16'd0);

    // R8 month: only month enabled
    wr(3'd0, 16'h0050);
    wr(3'd5, 16'h0010);
    cal_month = 8'h10; tick_once();
    check("R8 one-based no match", {15'd0, alarm_pending}, 16'd0);
    cal_month = 8'h11; tick_once();
    check("R8 index match", {15'd0, alarm_pending}, 16'd1);
    wr(3'd7, 16'h0002);
    wr(3'd5, 16'h0000);
    cal_month = 8'h01; tick_once();
    check("R8 january", {15'd0, alarm_pending}, 16'd1);
    rd("R6 status bit1", 3'd7, 16'h0002);

    // R7 bit 0 alone does nothing
    wr(3'd7, 16'h0001);
    check("R7 bit0 ignored", {15'd0, alarm_pending}, 16'd1);
    check("R7 bit0 irq", {15'd0, alarm_irq}, 16'd1);

    // R9 collision: clear write and alarm same cycle
    @(negedge clk); reg_wr = 1; reg_sel = 3'd7; reg_wdata = 16'h0002; sec_tick = 1;
    @(negedge clk); reg_wr = 0; sec_tick = 0;
    check("R9 set wins", {15'd0, alarm_pending}, 16'd1);
    wr(3'd7, 16'h0002);
    check("R7 final clear", {15'd0, alarm_irq}, 16'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule